// File: doc/BRIEF.md
# Fixed Time-Division Frame Multiplexer and Demultiplexer

This block carries twenty-four byte-wide sub-channels over one serial line using fixed time-division framing. Each frame is 193 bit times long. It opens with a single framing bit, and then carries one byte for every sub-channel. The bytes follow in ascending sub-channel order and are sent most significant bit first. A sub-channel has no header or tag. Its address is simply the position of its slot, counted from the framing bit. Every sub-channel gets the same fixed share of the line in every frame, whether or not its byte carries anything useful.

The transmit half is a two-state machine. `TX_FBIT` drives the framing bit. The transition `T_TX_OPEN` leads into `TX_DATA`, which shifts out the 192 payload bits. `T_TX_CLOSE` returns to `TX_FBIT` after the last bit of the last slot. All 24 input bytes are copied into a holding register on the clock edge that ends the framing-bit cycle, so no byte is ever split across two frames. The framing bit is 1 in the first frame after reset and alternates on every frame after that.

The receive half has three states. It starts in `RX_HUNT`. An external frame-start strobe marks the framing bit, and from any state the transition `T_RX_ALIGN` moves to `RX_DATA` with slot 0 next. After the last slot, `T_RX_WRAP` enters `RX_FBIT`, which treats one bit as the framing bit without needing a strobe. `T_RX_FLY` then resumes `RX_DATA` for the next frame. Searching for the frame alignment is left to the logic that drives the strobe.

Top module: `tdm_framer`

## Requirements
- R1: `tx_frame_start` is high in exactly one cycle of every 193. That cycle is the framing-bit cycle, and the first one is the cycle right after reset is released. During reset, `tx_frame_start` reads 1.
- R2: The framing bit on `tx_ser` is 1 in the first frame after reset and inverts in each following frame.
- R3: Slot s (s = 0..23) carries `tx_chan_data[8s+7:8s]`. Counting the framing bit as position 0, the slot occupies frame positions 8s+1 to 8s+8, most significant bit first.
- R4: `tx_chan_data` is sampled only on the clock edge that ends the framing-bit cycle. A change at any other time has no effect on `tx_ser` until the next frame.
- R5: After reset the receiver stays in `RX_HUNT`. It keeps `rx_valid` low until it sees `rx_frame_start`.
- R6: The bit present while `rx_frame_start` is high is the framing bit and is never delivered as data. The next 192 bits are recovered as slots 0..23.
- R7: `rx_valid` is high in the cycle in which the eighth bit of a slot is on `rx_ser`. In that cycle, `rx_byte` holds the slot's byte, built MSB first and including the bit currently on the line, and `rx_slot` holds the slot index. When `rx_valid` is low, `rx_byte` and `rx_slot` are 0.
- R8: With no strobe, the receiver treats the bit after slot 23 as the framing bit and recovers the next frame with the same alignment.
- R9: `rx_frame_start` realigns the receiver in any state and at any bit position. No valid pulse occurs in that cycle, and the next bit is the MSB of slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_chan_data | input | 192 | 24 sub-channel bytes; slot s in bits 8s+7..8s |
| tx_ser | output | 1 | Serial frame output |
| tx_frame_start | output | 1 | High during the framing-bit cycle |
| rx_ser | input | 1 | Serial frame input |
| rx_frame_start | input | 1 | Marks the framing bit on `rx_ser` |
| rx_byte | output | 8 | Recovered slot byte, valid with `rx_valid` |
| rx_valid | output | 1 | High in the cycle a slot's last bit arrives |
| rx_slot | output | 5 | Index of the recovered slot |

## Verification
The transmit outputs are decoded from state registers only. The framing bit therefore appears in the first cycle after reset is released, and payload position k appears k cycles later. The captured input bytes take effect in the cycle after the framing bit. The receive outputs depend combinationally on `rx_ser` and `rx_frame_start`, so a byte is due in the same cycle as its last bit and a realignment strobe takes effect at once. The bench changes inputs 2 ns after each rising edge and compares every output at each falling edge against a behavioural frame-position model. Each comparison therefore sees the settled result of the current cycle.

// File: rtl/tdm_pkg.sv
package tdm_pkg;

    typedef enum logic {
        TX_FBIT,
        TX_DATA
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_HUNT,
        RX_DATA,
        RX_FBIT
    } rx_state_e;

endpackage

// File: rtl/tdm_slot_ctr.sv
module tdm_slot_ctr #(
    parameter int NUM_CH = 24,
    parameter int CH_W   = 8,
    localparam int SLOT_W = $clog2(NUM_CH),
    localparam int BIT_W  = $clog2(CH_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              adv,
    output logic [BIT_W-1:0]  bit_idx,
    output logic [SLOT_W-1:0] slot_idx,
    output logic              last_bit,
    output logic              last_slot
);

    assign last_bit  = (bit_idx == BIT_W'(CH_W - 1));
    assign last_slot = (slot_idx == SLOT_W'(NUM_CH - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_idx  <= '0;
            slot_idx <= '0;
        end else if (clr) begin
            bit_idx  <= '0;
            slot_idx <= '0;
        end else if (adv) begin
            if (last_bit) begin
                bit_idx  <= '0;
                slot_idx <= last_slot ? '0 : slot_idx + 1'b1;
            end else begin
                bit_idx <= bit_idx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/tdm_tx.sv
module tdm_tx
    import tdm_pkg::*;
#(
    parameter int NUM_CH = 24,
    parameter int CH_W   = 8,
    localparam int SLOT_W = $clog2(NUM_CH),
    localparam int BIT_W  = $clog2(CH_W)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_CH*CH_W-1:0] chan_in,
    output logic                   ser_out,
    output logic                   frame_start
);

    tx_state_e         state_q;
    tx_state_e         state_d;
    logic              fbit_q;
    logic [CH_W-1:0]   snap [NUM_CH];
    logic [BIT_W-1:0]  bit_idx;
    logic [SLOT_W-1:0] slot_idx;
    logic              last_bit;
    logic              last_slot;
    logic [CH_W-1:0]   cur_byte;
    logic [BIT_W-1:0]  bit_sel;

    tdm_slot_ctr #(
        .NUM_CH (NUM_CH),
        .CH_W   (CH_W)
    ) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (state_q == TX_FBIT),
        .adv       (state_q == TX_DATA),
        .bit_idx   (bit_idx),
        .slot_idx  (slot_idx),
        .last_bit  (last_bit),
        .last_slot (last_slot)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_FBIT;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_FBIT: state_d = TX_DATA;                               // T_TX_OPEN
            TX_DATA: if (last_bit && last_slot) state_d = TX_FBIT;    // T_TX_CLOSE
        endcase
    end

    // framing bit polarity, flips as each frame opens
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fbit_q <= 1'b1;
        end else if (state_q == TX_FBIT) begin
            fbit_q <= ~fbit_q;
        end
    end

    // per-channel holding bytes, captured once per frame
    for (genvar g = 0; g < NUM_CH; g++) begin : g_snap
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                snap[g] <= '0;
            end else if (state_q == TX_FBIT) begin
                snap[g] <= chan_in[g*CH_W +: CH_W];
            end
        end
    end

    assign cur_byte = snap[slot_idx];
    assign bit_sel  = BIT_W'(CH_W - 1) - bit_idx;

    // outputs
    always_comb begin
        ser_out     = 1'b0;
        frame_start = 1'b0;
        unique case (state_q)
            TX_FBIT: begin
                ser_out     = fbit_q;
                frame_start = 1'b1;
            end
            TX_DATA: begin
                ser_out     = cur_byte[bit_sel];
                frame_start = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/tdm_rx.sv
module tdm_rx
    import tdm_pkg::*;
#(
    parameter int NUM_CH = 24,
    parameter int CH_W   = 8,
    localparam int SLOT_W = $clog2(NUM_CH),
    localparam int BIT_W  = $clog2(CH_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_in,
    input  logic              sync_in,
    output logic [CH_W-1:0]   byte_out,
    output logic              byte_valid,
    output logic [SLOT_W-1:0] slot_out
);

    rx_state_e         state_q;
    rx_state_e         state_d;
    logic [CH_W-2:0]   shreg;
    logic [BIT_W-1:0]  bit_idx;
    logic [SLOT_W-1:0] slot_idx;
    logic              last_bit;
    logic              last_slot;

    tdm_slot_ctr #(
        .NUM_CH (NUM_CH),
        .CH_W   (CH_W)
    ) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (sync_in || (state_q != RX_DATA)),
        .adv       (state_q == RX_DATA),
        .bit_idx   (bit_idx),
        .slot_idx  (slot_idx),
        .last_bit  (last_bit),
        .last_slot (last_slot)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_HUNT;
        end else begin
            state_d_check: state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (sync_in) begin
            state_d = RX_DATA;                                        // T_RX_ALIGN
        end else begin
            unique case (state_q)
                RX_HUNT: state_d = RX_HUNT;
                RX_DATA: if (last_bit && last_slot) state_d = RX_FBIT; // T_RX_WRAP
                RX_FBIT: state_d = RX_DATA;                           // T_RX_FLY
                default: state_d = RX_HUNT;
            endcase
        end
    end

    // partial byte, oldest bit on the left
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (state_q == RX_DATA && !sync_in) begin
            shreg <= {shreg[CH_W-3:0], ser_in};
        end
    end

    // outputs
    always_comb begin
        byte_out   = '0;
        byte_valid = 1'b0;
        slot_out   = '0;
        unique case (state_q)
            RX_DATA: begin
                if (!sync_in && last_bit) begin
                    byte_out   = {shreg, ser_in};
                    byte_valid = 1'b1;
                    slot_out   = slot_idx;
                end
            end
            RX_HUNT, RX_FBIT: begin
                byte_valid = 1'b0;
            end
            default: begin
                byte_valid = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/tdm_framer.sv
module tdm_framer #(
    parameter int NUM_CH = 24,
    parameter int CH_W   = 8,
    localparam int SLOT_W = $clog2(NUM_CH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_CH*CH_W-1:0] tx_chan_data,
    output logic                   tx_ser,
    output logic                   tx_frame_start,
    input  logic                   rx_ser,
    input  logic                   rx_frame_start,
    output logic [CH_W-1:0]        rx_byte,
    output logic                   rx_valid,
    output logic [SLOT_W-1:0]      rx_slot
);

    tdm_tx #(
        .NUM_CH (NUM_CH),
        .CH_W   (CH_W)
    ) u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .chan_in     (tx_chan_data),
        .ser_out     (tx_ser),
        .frame_start (tx_frame_start)
    );

    tdm_rx #(
        .NUM_CH (NUM_CH),
        .CH_W   (CH_W)
    ) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_in     (rx_ser),
        .sync_in    (rx_frame_start),
        .byte_out   (rx_byte),
        .byte_valid (rx_valid),
        .slot_out   (rx_slot)
    );

endmodule

// File: rtl/tdm_framer_chk.sv
module tdm_framer_chk #(
    parameter int NUM_CH = 24,
    parameter int CH_W   = 8,
    localparam int SLOT_W = $clog2(NUM_CH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tx_frame_start,
    input logic              tx_ser,
    input logic              rx_frame_start,
    input logic              rx_valid,
    input logic [SLOT_W-1:0] rx_slot
);

    localparam int FRAME_BITS = NUM_CH * CH_W + 1;

    logic [15:0] gap;
    logic        seen;
    logic        last_fb;
    logic        rx_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap     <= '0;
            seen    <= 1'b0;
            last_fb <= 1'b0;
            rx_seen <= 1'b0;
        end else begin
            if (tx_frame_start) begin
                gap     <= '0;
                seen    <= 1'b1;
                last_fb <= tx_ser;
            end else begin
                gap <= gap + 16'd1;
            end
            if (rx_frame_start) begin
                rx_seen <= 1'b1;
            end
        end
    end

    AST_TX_FRAME_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        seen |-> (tx_frame_start == (gap == 16'(FRAME_BITS - 1)))); // R1

    AST_TX_FIRST_FBIT: assert property (@(posedge clk) disable iff (!rst_n)
        (!seen && tx_frame_start) |-> tx_ser); // R2

    AST_TX_FBIT_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && tx_frame_start) |-> (tx_ser != last_fb)); // R2

    AST_RX_HUNT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_seen |-> !rx_valid); // R5

    AST_RX_SYNC_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        rx_frame_start |-> !rx_valid); // R9

    AST_RX_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (rx_slot < SLOT_W'(NUM_CH))); // R7

    AST_RX_VALID_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R7

    AST_RX_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> (rx_slot == '0)); // R7

endmodule

bind tdm_framer tdm_framer_chk #(
    .NUM_CH (NUM_CH),
    .CH_W   (CH_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .tx_frame_start (tx_frame_start),
    .tx_ser         (tx_ser),
    .rx_frame_start (rx_frame_start),
    .rx_valid       (rx_valid),
    .rx_slot        (rx_slot)
);

// File: tb/sim_tdm_framer.sv
`timescale 1ns/1ps
module sim_tdm_framer;

    localparam int NCH = 24;
    localparam int FB  = NCH * 8 + 1;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [NCH*8-1:0] chan;
    logic           tx_ser;
    logic           tx_fs;
    logic           rx_ser_w;
    logic           rx_fs_w;
    logic [7:0]     rx_byte;
    logic           rx_valid;
    logic [4:0]     rx_slot;
    logic           loop_sel;
    logic           sync_sel;
    logic           rx_ser_drv;
    logic           rx_fs_drv;

    int n_tests = 0;
    int n_fail  = 0;

    // model state
    int        m_pos;
    logic      m_fb;
    logic [7:0] m_snap [NCH];
    logic      m_hunt;
    int        m_rpos;
    int        m_sh;
    int        m_fly;

    always #4 clk = ~clk;

    assign rx_ser_w = loop_sel ? tx_ser : rx_ser_drv;
    assign rx_fs_w  = sync_sel ? tx_fs  : rx_fs_drv;

    tdm_framer u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .tx_chan_data   (chan),
        .tx_ser         (tx_ser),
        .tx_frame_start (tx_fs),
        .rx_ser         (rx_ser_w),
        .rx_frame_start (rx_fs_w),
        .rx_byte        (rx_byte),
        .rx_valid       (rx_valid),
        .rx_slot        (rx_slot)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        int   s;
        int   b;
        logic e_fs;
        logic e_ser;
        logic e_v;
        int   e_b;
        int   e_s;
        string tag;
        if (!rst_n) begin
            m_pos  = 0;
            m_fb   = 1'b1;
            m_hunt = 1'b1;
            m_rpos = 0;
            m_sh   = 0;
            m_fly  = 0;
            for (int i = 0; i < NCH; i++) m_snap[i] = 8'h00;
        end
        // transmit expectations
        e_fs = (m_pos == 0);
        if (m_pos == 0) begin
            e_ser = m_fb;
        end else begin
            s = (m_pos - 1) / 8;
            b = 7 - ((m_pos - 1) % 8);
            e_ser = m_snap[s][b];
        end
        chk(tx_fs === e_fs, "R1 frame start", int'(tx_fs), int'(e_fs));
        chk(tx_ser === e_ser, (m_pos == 0) ? "R2 framing bit" : "R3 R4 payload bit",
            int'(tx_ser), int'(e_ser));
        // receive expectations
        e_v = 1'b0; e_b = 0; e_s = 0;
        if (!rx_fs_w && !m_hunt && m_rpos >= 1 && ((m_rpos - 1) % 8) == 7) begin
            e_v = 1'b1;
            e_s = (m_rpos - 1) / 8;
            e_b = ((m_sh << 1) | int'(rx_ser_w)) & 255;
        end
        tag = rx_fs_w ? "R9 realign" : (m_hunt ? "R5 hunt" : (m_fly > 0 ? "R8 R7 flywheel" : "R6 R7 recover"));
        chk(rx_valid === e_v, tag, int'(rx_valid), int'(e_v));
        chk(rx_byte === 8'(e_b), tag, int'(rx_byte), e_b);
        chk(rx_slot === 5'(e_s), tag, int'(rx_slot), e_s);
        // advance to next cycle
        if (rst_n) begin
            if (m_pos == 0) begin
                for (int i = 0; i < NCH; i++) m_snap[i] = chan[i*8 +: 8];
            end
            m_pos++;
            if (m_pos == FB) begin
                m_pos = 0;
                m_fb  = ~m_fb;
            end
            if (rx_fs_w) begin
                m_hunt = 1'b0;
                m_rpos = 1;
                m_fly  = 0;
            end else if (!m_hunt) begin
                if (m_rpos >= 1) m_sh = ((m_sh << 1) | int'(rx_ser_w)) & 255;
                if (m_rpos == FB - 1) begin
                    m_rpos = 0;
                    m_fly++;
                end else begin
                    m_rpos++;
                end
            end
        end
    end

    function automatic logic [NCH*8-1:0] pattern(input int k);
        logic [NCH*8-1:0] v;
        for (int c = 0; c < NCH; c++) begin
            case (k % 5)
                0: v[c*8 +: 8] = 8'h00;
                1: v[c*8 +: 8] = 8'hFF;
                2: v[c*8 +: 8] = 8'hA5 ^ 8'(c);
                3: v[c*8 +: 8] = 8'(c + 1);
                default: v[c*8 +: 8] = 8'($urandom);
            endcase
        end
        return v;
    endfunction

    initial begin
        rst_n      = 1'b0;
        chan       = pattern(3);
        loop_sel   = 1'b1;
        sync_sel   = 1'b0;
        rx_ser_drv = 1'b0;
        rx_fs_drv  = 1'b0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // loopback frames; input bytes change mid-frame (R4)
        for (int k = 0; k < 12; k++) begin
            if (k == 2) sync_sel = 1'b1;   // R6 alignment from tx strobe
            if (k == 5) sync_sel = 1'b0;   // R8 flywheel frames
            if (k == 9) sync_sel = 1'b1;
            repeat (97) @(posedge clk);
            #2 chan = pattern(k + 1);
            repeat (96) @(posedge clk);
        end
        // direct drive with realignment strobes (R9)
        @(posedge clk);
        #2 loop_sel = 1'b0;
        sync_sel = 1'b0;
        for (int cyc = 0; cyc < 1500; cyc++) begin
            @(posedge clk);
            #2;
            rx_ser_drv = 1'($urandom);
            rx_fs_drv  = (cyc == 5 || cyc == 120 || cyc == 128 || cyc == 500 ||
                          cyc == 693 || cyc == 700 || cyc == 1300);
        end
        @(posedge clk);
        #2 rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule